// File: doc/BRIEF.md
# Three-Wire Serial Programming Port

This block is the write-only configuration port of a radio transceiver. A host drives three lines: a serial data line, a serial clock and an active-low enable. While the enable is low, each rising edge of the serial clock moves one data bit into a shift register, most significant bit first. When the enable returns high, the last four bits shifted in are read as an address. The bits shifted in before them are then written, as one word, into the latch that address selects. All three lines are sampled into the system clock domain through two-flop synchronisers, and the edges are detected in that domain.

There are three functional latches: the RF synthesizer divider word, the receive gain word (gain code plus low-noise-amplifier enable) and the operating-mode/control word. Each latch holds a preset value after reset. Writes to the RF divider are staged. They reach the divider output only when the divider reports a safe update point, so the ratio never changes while the dividers are reading it. The port has no bit counter. Extra leading bits fall off the top of the shift register, and only the most recent frame-width bits count.

Top module: `tw_prog_port`

## Requirements
- R1: Serial clock edges that occur while the enable is high shift nothing. A later enable low-then-high with no clock edges reloads the previously shifted frame unchanged.
- R2: The bit shifted in first lands in the most significant frame position. The frame is 19 bits: bits 18..4 are the data field (bit 18 first on the wire) and bits 3..0 are the address.
- R3: On a rising edge of the enable, the address decides the destination latch: 4'b0011 selects the RF divider, 4'b0101 the gain word and 4'b1001 the control word.
- R4: Any number of extra bits shifted in before the final 19 bits has no effect on the loaded value.
- R5: A frame loads correctly whether the serial clock is high or low when the enable rises. Each enable rise produces exactly one single-cycle load.
- R6: A gain write sets gain_atten to data bits 5..0 and lna_en to data bit 6.
- R7: Writes to address 4'b0000 and to any other address outside R3 change no latch output.
- R8: A control write sets ctrl_word to data bits 10..0, where bit 0 = transmit on, 1 = receive on, 2 = synthesizer on, 3 = transmit IF on, 4 = high band, 5 = infradyne, 6 = half charge-pump current, 7 = IF divide-by-2, 8 = IF synthesizer divide-by-7, 9 = reference divide-by-130 and 10 = 91 MHz IF filter.
- R9: An RF divider write does not reach rf_div_word while div_safe is low. It appears on the cycle after div_safe is high.
- R10: After reset, rf_div_word = 9350, gain_atten = 0, lna_en = 1 and ctrl_word = 0.
- R11: When several RF divider writes arrive before a safe point, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, applies presets |
| ser_clk | input | 1 | Serial programming clock |
| ser_data | input | 1 | Serial programming data |
| ser_en_n | input | 1 | Active-low frame enable |
| div_safe | input | 1 | RF divider signals that its word may be updated |
| rf_div_word | output | 15 | RF divider ratio word |
| gain_atten | output | 6 | Receive gain attenuation code |
| lna_en | output | 1 | Low-noise amplifier enable |
| ctrl_word | output | 11 | Mode and control bits |

## Verification
Two situations are hard to reach from the ports. The first is an RF word that is pending while the divider is busy and is then overwritten by a second write. The bench holds div_safe low across two complete RF frames, checks that the output still shows the preset, and only then gives one safe pulse. The second is the proof that clock edges are ignored while the enable is high. The bench toggles a full conflicting frame with the enable high, then pulses the enable without any clocks, so the untouched shift register is reloaded and its contents become visible at the outputs.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int ADDR_W = 4;
  localparam int GAIN_W = 7;
  localparam int CTRL_W = 11;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RF   = 2'd1,
    DST_GAIN = 2'd2,
    DST_CTRL = 2'd3
  } dst_e;

  // Map a 4-bit address onto a destination latch; anything else is dropped.
  function automatic dst_e classify(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] a_rf,
                                    input logic [ADDR_W-1:0] a_gain,
                                    input logic [ADDR_W-1:0] a_ctrl);
    dst_e d;
    if (addr == '0)          d = DST_NONE;
    else if (addr == a_rf)   d = DST_RF;
    else if (addr == a_gain) d = DST_GAIN;
    else if (addr == a_ctrl) d = DST_CTRL;
    else                     d = DST_NONE;
    return d;
  endfunction

endpackage

// File: rtl/tw_front.sv
module tw_front #(
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_en_n,
  output logic [FRAME_W-1:0] frame,
  output logic               shift_evt,
  output logic               en_rise,
  output logic               en_level
);
  // lane 0 = clock, lane 1 = data, lane 2 = enable (idles high)
  localparam int          LANES    = 3;
  localparam logic [2:0]  SYNC_RST = 3'b100;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] meta_q;
  logic [LANES-1:0] sync_q;
  logic             clk_prev_q;
  logic             en_prev_q;

  assign raw = {ser_en_n, ser_data, ser_clk};

  for (genvar i = 0; i < LANES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= SYNC_RST[i];
        sync_q[i] <= SYNC_RST[i];
      end else begin
        meta_q[i] <= raw[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      en_prev_q  <= 1'b1;
    end else begin
      clk_prev_q <= sync_q[0];
      en_prev_q  <= sync_q[2];
    end
  end

  assign en_level  = sync_q[2];
  assign shift_evt = sync_q[0] & ~clk_prev_q & ~sync_q[2];
  assign en_rise   = sync_q[2] & ~en_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame <= '0;
    else if (shift_evt) frame <= {frame[FRAME_W-2:0], sync_q[1]};
  end

endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
#(
  parameter int               DATA_W = 15,
  parameter logic [ADDR_W-1:0] A_RF   = 4'b0011,
  parameter logic [ADDR_W-1:0] A_GAIN = 4'b0101,
  parameter logic [ADDR_W-1:0] A_CTRL = 4'b1001,
  localparam int              FRAME_W = DATA_W + ADDR_W
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic               en_rise,
  output logic               load_pulse,
  output dst_e               load_dst,
  output logic [DATA_W-1:0]  load_data
);

  function automatic logic [ADDR_W-1:0] tail_addr(input logic [FRAME_W-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] head_data(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  dst_e target;

  always_comb begin
    target     = classify(tail_addr(frame), A_RF, A_GAIN, A_CTRL);
    load_dst   = en_rise ? target : DST_NONE;
    load_pulse = en_rise && (target != DST_NONE);
    load_data  = head_data(frame);
  end

endmodule

// File: rtl/tw_latch.sv
module tw_latch #(
  parameter int           W      = 8,
  parameter logic [W-1:0] PRESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= PRESET;
    else if (we) q <= d;
  end
endmodule

// File: rtl/tw_rf_stage.sv
module tw_rf_stage #(
  parameter int           W      = 15,
  parameter logic [W-1:0] PRESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic         div_safe,
  output logic         pend_valid,
  output logic [W-1:0] pend_word,
  output logic         commit,
  output logic [W-1:0] q
);
  assign commit = pend_valid & div_safe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_word  <= PRESET;
      q          <= PRESET;
    end else begin
      if (commit) q <= pend_word;
      if (we) begin
        pend_word  <= d;
        pend_valid <= 1'b1;
      end else if (commit) begin
        pend_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tw_prog_port.sv
module tw_prog_port
  import tw_pkg::*;
#(
  parameter int                 DATA_W      = 15,
  parameter logic [ADDR_W-1:0]  A_RF        = 4'b0011,
  parameter logic [ADDR_W-1:0]  A_GAIN      = 4'b0101,
  parameter logic [ADDR_W-1:0]  A_CTRL      = 4'b1001,
  parameter logic [DATA_W-1:0]  RF_PRESET   = 15'd9350,
  parameter logic [GAIN_W-1:0]  GAIN_PRESET = 7'b1_000000,
  parameter logic [CTRL_W-1:0]  CTRL_PRESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en_n,
  input  logic              div_safe,
  output logic [DATA_W-1:0] rf_div_word,
  output logic [5:0]        gain_atten,
  output logic              lna_en,
  output logic [CTRL_W-1:0] ctrl_word
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  // Named internal events, exposed for the bound checker
  logic [FRAME_W-1:0] frame;
  logic               shift_evt;
  logic               en_rise;
  logic               en_level;
  logic               load_pulse;
  dst_e               load_dst;
  logic [DATA_W-1:0]  load_data;
  logic               rf_pending;
  logic [DATA_W-1:0]  rf_pend_word;
  logic               rf_commit;
  logic [GAIN_W-1:0]  gain_q;

  tw_front #(.FRAME_W(FRAME_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_en_n  (ser_en_n),
    .frame     (frame),
    .shift_evt (shift_evt),
    .en_rise   (en_rise),
    .en_level  (en_level)
  );

  tw_decode #(
    .DATA_W (DATA_W),
    .A_RF   (A_RF),
    .A_GAIN (A_GAIN),
    .A_CTRL (A_CTRL)
  ) u_decode (
    .frame      (frame),
    .en_rise    (en_rise),
    .load_pulse (load_pulse),
    .load_dst   (load_dst),
    .load_data  (load_data)
  );

  tw_rf_stage #(.W(DATA_W), .PRESET(RF_PRESET)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (load_pulse && load_dst == DST_RF),
    .d          (load_data),
    .div_safe   (div_safe),
    .pend_valid (rf_pending),
    .pend_word  (rf_pend_word),
    .commit     (rf_commit),
    .q          (rf_div_word)
  );

  tw_latch #(.W(GAIN_W), .PRESET(GAIN_PRESET)) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (load_pulse && load_dst == DST_GAIN),
    .d     (load_data[GAIN_W-1:0]),
    .q     (gain_q)
  );

  tw_latch #(.W(CTRL_W), .PRESET(CTRL_PRESET)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (load_pulse && load_dst == DST_CTRL),
    .d     (load_data[CTRL_W-1:0]),
    .q     (ctrl_word)
  );

  assign gain_atten = gain_q[5:0];
  assign lna_en     = gain_q[6];

endmodule

// File: rtl/tw_prog_port_chk.sv
module tw_prog_port_chk
  import tw_pkg::*;
#(
  parameter int DATA_W  = 15,
  parameter int FRAME_W = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift_evt,
  input logic               en_level,
  input logic [FRAME_W-1:0] frame,
  input logic               load_pulse,
  input dst_e               load_dst,
  input logic               div_safe,
  input logic               rf_pending,
  input logic [DATA_W-1:0]  rf_pend_word,
  input logic [DATA_W-1:0]  rf_div_word,
  input logic [5:0]         gain_atten,
  input logic               lna_en,
  input logic [CTRL_W-1:0]  ctrl_word
);

  AST_NO_SHIFT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> !en_level); // R1

  AST_FRAME_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_level |=> $stable(frame)); // R1

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R5

  AST_GAIN_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pulse && load_dst == DST_GAIN) |=> $stable({lna_en, gain_atten})); // R6

  AST_CTRL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pulse && load_dst == DST_CTRL) |=> $stable(ctrl_word)); // R8

  AST_DISCARD_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pulse && load_dst == DST_NONE && !div_safe) |=>
      ($stable(rf_div_word) && $stable(ctrl_word) && $stable(gain_atten))); // R7

  AST_RF_HOLD_UNSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !div_safe |=> $stable(rf_div_word)); // R9

  AST_RF_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_pending && div_safe) |=> (rf_div_word == $past(rf_pend_word))); // R9

endmodule

bind tw_prog_port tw_prog_port_chk #(
  .DATA_W  (DATA_W),
  .FRAME_W (FRAME_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_evt    (shift_evt),
  .en_level     (en_level),
  .frame        (frame),
  .load_pulse   (load_pulse),
  .load_dst     (load_dst),
  .div_safe     (div_safe),
  .rf_pending   (rf_pending),
  .rf_pend_word (rf_pend_word),
  .rf_div_word  (rf_div_word),
  .gain_atten   (gain_atten),
  .lna_en       (lna_en),
  .ctrl_word    (ctrl_word)
);

// File: tb/tw_prog_port_test.sv
module tw_prog_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_en_n = 1'b1;
  logic        div_safe = 1'b0;
  logic [14:0] rf_div_word;
  logic [5:0]  gain_atten;
  logic        lna_en;
  logic [10:0] ctrl_word;

  int tests = 0;
  int fails = 0;

  tw_prog_port uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .ser_data    (ser_data),
    .ser_en_n    (ser_en_n),
    .div_safe    (div_safe),
    .rf_div_word (rf_div_word),
    .gain_atten  (gain_atten),
    .lna_en      (lna_en),
    .ctrl_word   (ctrl_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b);
    ser_data = b;
    ser_clk  = 1'b0;
    tick(HALF_BIT);
    ser_clk  = 1'b1;
    tick(HALF_BIT);
  endtask

  // Frame on the wire: data[14] first ... data[0], then addr[3] ... addr[0]
  task automatic send_frame(input logic [14:0] data, input logic [3:0] addr,
                            input bit end_high, input int junk_bits,
                            input logic [7:0] junk);
    logic [18:0] f;
    f = {data, addr};
    ser_en_n = 1'b0;
    tick(HALF_BIT);
    for (int j = junk_bits - 1; j >= 0; j--) clock_bit(junk[j]);
    for (int i = 18; i >= 0; i--) clock_bit(f[i]);
    if (!end_high) begin
      ser_clk = 1'b0;
      tick(HALF_BIT);
    end
    ser_en_n = 1'b1;
    tick(8);
    ser_clk = 1'b0;
    tick(HALF_BIT);
  endtask

  task automatic t_reset;
    check("R10", "rf preset",   32'(rf_div_word), 32'd9350);
    check("R10", "gain preset", 32'(gain_atten),  32'd0);
    check("R10", "lna preset",  32'(lna_en),      32'd1);
    check("R10", "ctrl preset", 32'(ctrl_word),   32'd0);
  endtask

  task automatic t_gain;
    send_frame({8'd0, 1'b0, 6'b101100}, 4'b0101, 1'b0, 0, 8'h00);
    check("R6", "gain code", 32'(gain_atten), 32'b101100);
    check("R2", "lna bit",   32'(lna_en),     32'd0);
    check("R3", "ctrl untouched by gain addr", 32'(ctrl_word), 32'd0);
  endtask

  task automatic t_ctrl;
    send_frame({4'd0, 11'b101_1001_0011}, 4'b1001, 1'b0, 0, 8'h00);
    check("R8", "ctrl word", 32'(ctrl_word), 32'b101_1001_0011);
    check("R3", "gain untouched by ctrl addr", 32'(gain_atten), 32'b101100);
  endtask

  task automatic t_leading;
    send_frame({8'd0, 1'b1, 6'b010011}, 4'b0101, 1'b0, 7, 8'b0101_0111);
    check("R4", "gain after leading junk", 32'(gain_atten), 32'b010011);
    check("R4", "lna after leading junk",  32'(lna_en),     32'd1);
  endtask

  task automatic t_clk_high;
    send_frame({4'd0, 11'b010_0110_1100}, 4'b1001, 1'b1, 0, 8'h00);
    check("R5", "ctrl with clock high at enable rise", 32'(ctrl_word), 32'b010_0110_1100);
  endtask

  task automatic t_forbidden;
    div_safe = 1'b1;
    send_frame(15'h7FFF, 4'b0000, 1'b0, 0, 8'h00);
    send_frame(15'h7FFF, 4'b1111, 1'b0, 0, 8'h00);
    div_safe = 1'b0;
    tick(2);
    check("R7", "gain after discarded writes", 32'(gain_atten), 32'b010011);
    check("R7", "lna after discarded writes",  32'(lna_en),     32'd1);
    check("R7", "ctrl after discarded writes", 32'(ctrl_word),  32'b010_0110_1100);
    check("R7", "rf after discarded writes",   32'(rf_div_word), 32'd9350);
  endtask

  task automatic t_rf_defer;
    send_frame(15'h5A3C, 4'b0011, 1'b0, 0, 8'h00);
    check("R9", "rf held while unsafe", 32'(rf_div_word), 32'd9350);
    send_frame(15'h1234, 4'b0011, 1'b0, 0, 8'h00);
    check("R11", "rf still held after second write", 32'(rf_div_word), 32'd9350);
    div_safe = 1'b1;
    tick(1);
    div_safe = 1'b0;
    tick(2);
    check("R11", "last rf write applied", 32'(rf_div_word), 32'h1234);
    check("R9", "gain untouched by rf write", 32'(gain_atten), 32'b010011);
  endtask

  task automatic t_idle_clk;
    logic [18:0] f;
    send_frame({8'd0, 1'b1, 6'b000111}, 4'b0101, 1'b0, 0, 8'h00);
    check("R1", "gain before idle clocks", 32'(gain_atten), 32'b000111);
    f = {15'h07FF, 4'b1001};
    for (int i = 18; i >= 0; i--) clock_bit(f[i]);
    ser_clk = 1'b0;
    tick(HALF_BIT);
    ser_en_n = 1'b0;
    tick(8);
    ser_en_n = 1'b1;
    tick(8);
    check("R1", "ctrl unchanged by idle clocks", 32'(ctrl_word),  32'b010_0110_1100);
    check("R1", "gain reloaded from old frame",  32'(gain_atten), 32'b000111);
    check("R5", "lna reloaded from old frame",   32'(lna_en),     32'd1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_gain();
    t_ctrl();
    t_leading();
    t_clk_high();
    t_forbidden();
    t_rf_defer();
    t_idle_clk();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule